// File: doc/BRIEF.md
# Receive Symbol Boundary Aligner

This block sits right after a 1:10 deserializer. The deserializer delivers 10-bit words whose boundary is arbitrary with respect to the line code. The block keeps the last two received words as one 19-bit sliding window. From that window it picks the 10 bits that start at a chosen boundary offset (0 to 9) and presents them as the aligned symbol. At every offset it searches for the K28.5 comma at the same time, in both running disparities.

The offset is managed in one of four runtime-selectable ways:

- **Two manual pattern modes.** A pattern-align enable gates realignment. It is either level-sensitive, or a single realignment is armed by the enable's rising edge.
- **External bit-slip mode.** Each rising edge of a slip input moves the boundary by one bit.
- **Automatic mode.** For 8B/10B-coded streams, a synchronization machine acquires the boundary from repeated commas, reports link synchronization, and drops it on a run of invalid code groups.

The aligned word and a comma-detect flag are registered outputs with a fixed latency.

Top module: `rx_word_aligner`

## Requirements
- R1: The aligned output is the 10-bit slice of the window {current word, previous word} that starts at bit position `offset` of the previous word. Offset 0 presents the previous word unchanged. The offset always stays in 0..9, and `data_o` is registered.
- R2: In level mode (`mode_i` = 0), while `align_en_i` is high a comma found at offset k sets the offset to k; the lowest k wins if several match. While `align_en_i` is low the offset holds.
- R3: In edge mode (`mode_i` = 1), a 0-to-1 transition of `align_en_i` arms one realignment, which is taken at the next comma. Holding `align_en_i` high causes no further realignment.
- R4: In slip mode (`mode_i` = 2), each 0-to-1 transition of `slip_i` adds one to the offset, and 9 wraps to 0. Commas never move the offset in this mode.
- R5: In slip mode, while `slip_i` shows no rising transition the offset never changes, so no bit is inserted or dropped.
- R6: The comma is 10'b0011111010 or 10'b1100000101, and it is recognised at each of the ten offsets.
- R7: `det_o` is high for exactly those cycles in which `data_o` holds one of the two comma values.
- R8: In automatic mode (`mode_i` = 3), while unsynchronized the offset follows each comma. `sync_o` rises after three successive commas found at the same offset, and a comma at a different offset restarts the count.
- R9: In automatic mode while synchronized, a code group is invalid when its count of ones is outside 4..6. Four invalid aligned words in a row clear `sync_o`, and any valid word restarts that count.
- R10: `sync_o` is held low in every mode other than automatic.
- R11: Synchronous active-high reset clears the offset to 0 and drives `data_o`, `det_o` and `sync_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered parallel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0 level, 1 edge, 2 slip, 3 automatic |
| din_i | input | 10 | Raw deserialized word, bit 0 earliest |
| align_en_i | input | 1 | Pattern-align enable for the manual modes |
| slip_i | input | 1 | Bit-slip request, acted on at its rising edge |
| data_o | output | 10 | Aligned symbol |
| det_o | output | 1 | Aligned symbol is a comma |
| sync_o | output | 1 | Automatic-mode synchronization status |

## Verification
The bench feeds a bit stream cut into words at each of the ten bit phases, with commas of alternating disparity. A window that matched one disparity only, or an offset index off by one, would show misaligned data at some phase.

Slip tests use 7 and 17 slips toward the same phase. A design without the 9-to-0 wrap, or one that slips on level rather than on edge, would land elsewhere.

The manual modes are checked after the stream phase moves. A level design that realigns with the enable low, or an edge design that keeps realigning while the enable is held high, would start to report commas. Automatic mode is checked at the exact cycle of synchronization, and also on a stream whose comma offset keeps moving. Two more streams are used: one with long runs of bad code groups, and one with isolated bad code groups. A wrong threshold or a counter that never clears would show up on these.

// File: rtl/rxwa_pkg.sv
package rxwa_pkg;
  typedef enum logic [1:0] {
    AM_LEVEL = 2'd0,
    AM_EDGE  = 2'd1,
    AM_SLIP  = 2'd2,
    AM_AUTO  = 2'd3
  } align_mode_e;

  localparam logic [9:0] COMMA_RDN = 10'b0011111010;
  localparam logic [9:0] COMMA_RDP = 10'b1100000101;
endpackage

// File: rtl/rxwa_window.sv
module rxwa_window #(
  parameter int W  = 10,
  parameter int OW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  din_i,
  input  logic [OW-1:0] off_i,
  output logic [W-1:0]  sel_o,
  output logic [W-1:0]  hit_o
);
  import rxwa_pkg::*;

  localparam int WIN_W = 2 * W - 1;

  logic [W-1:0]     cur_q;
  logic [W-1:0]     prev_q;
  logic [WIN_W-1:0] win;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= din_i;
      prev_q <= cur_q;
    end
  end

  assign win = {cur_q[W-2:0], prev_q};

  // one comparator pair per candidate boundary
  for (genvar k = 0; k < W; k++) begin : g_cmp
    assign hit_o[k] = (win[k +: W] == W'(COMMA_RDN)) ||
                      (win[k +: W] == W'(COMMA_RDP));
  end

  always_comb begin
    sel_o = prev_q;
    for (int k = 0; k < W; k++) begin
      if (off_i == OW'(k)) sel_o = win[k +: W];
    end
  end
endmodule

// File: rtl/rxwa_offset_ctl.sv
module rxwa_offset_ctl #(
  parameter int W  = 10,
  parameter int OW = $clog2(W)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  rxwa_pkg::align_mode_e mode_i,
  input  logic                  en_i,
  input  logic                  slip_i,
  input  logic [W-1:0]          hit_i,
  input  logic                  sync_i,
  output logic                  hit_any_o,
  output logic [OW-1:0]         hit_pos_o,
  output logic [OW-1:0]         off_o
);
  import rxwa_pkg::*;

  logic [OW-1:0] off_q;
  logic          en_d, slip_d, armed_q;
  logic          en_rise, slip_rise;

  always_comb begin
    hit_pos_o = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (hit_i[k]) hit_pos_o = OW'(k);
    end
  end

  assign hit_any_o = |hit_i;
  assign en_rise   = en_i & ~en_d;
  assign slip_rise = slip_i & ~slip_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q   <= '0;
      en_d    <= 1'b0;
      slip_d  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      en_d   <= en_i;
      slip_d <= slip_i;
      case (mode_i)
        AM_LEVEL: begin
          armed_q <= 1'b0;
          if (en_i && hit_any_o) off_q <= hit_pos_o;
        end
        AM_EDGE: begin
          if ((armed_q || en_rise) && hit_any_o) begin
            off_q   <= hit_pos_o;
            armed_q <= 1'b0;
          end else if (en_rise) begin
            armed_q <= 1'b1;
          end
        end
        AM_SLIP: begin
          armed_q <= 1'b0;
          if (slip_rise) off_q <= (off_q == OW'(W - 1)) ? '0 : off_q + 1'b1;
        end
        default: begin
          armed_q <= 1'b0;
          if (!sync_i && hit_any_o) off_q <= hit_pos_o;
        end
      endcase
    end
  end

  assign off_o = off_q;

  // R1
  off_range_chk: assert property (@(posedge clk) disable iff (rst)
    off_q < OW'(W));
  // R4
  slip_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == AM_SLIP && slip_i && !slip_d && off_q == OW'(W - 1)) |=> (off_q == '0));
  // R5
  slip_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == AM_SLIP && !(slip_i && !slip_d)) |=> $stable(off_q));
  // R2
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == AM_LEVEL && !en_i) |=> $stable(off_q));
endmodule

// File: rtl/rxwa_sync.sv
module rxwa_sync #(
  parameter int W        = 10,
  parameter int OW       = $clog2(W),
  parameter int GOOD_N   = 3,
  parameter int BAD_N    = 4,
  parameter int ONES_MIN = 4,
  parameter int ONES_MAX = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active_i,
  input  logic          hit_any_i,
  input  logic [OW-1:0] hit_pos_i,
  input  logic [W-1:0]  sel_i,
  output logic          sync_o
);
  localparam int GW = $clog2(GOOD_N + 1);
  localparam int BW = $clog2(BAD_N + 1);
  localparam int CW = $clog2(W + 1);

  logic [GW-1:0] good_q;
  logic [BW-1:0] bad_q;
  logic [OW-1:0] cand_q;
  logic          sync_q;
  logic [CW-1:0] ones;
  logic          valid;

  always_comb begin
    ones = '0;
    for (int b = 0; b < W; b++) ones = ones + CW'(sel_i[b]);
  end

  assign valid = (ones >= CW'(ONES_MIN)) && (ones <= CW'(ONES_MAX));

  always_ff @(posedge clk) begin
    if (rst || !active_i) begin
      good_q <= '0;
      bad_q  <= '0;
      cand_q <= '0;
      sync_q <= 1'b0;
    end else if (!sync_q) begin
      if (hit_any_i) begin
        cand_q <= hit_pos_i;
        if (good_q != '0 && hit_pos_i == cand_q) begin
          if (good_q == GW'(GOOD_N - 1)) begin
            sync_q <= 1'b1;
            good_q <= '0;
            bad_q  <= '0;
          end else begin
            good_q <= good_q + 1'b1;
          end
        end else begin
          good_q <= GW'(1);
        end
      end
    end else begin
      if (!valid) begin
        if (bad_q == BW'(BAD_N - 1)) begin
          sync_q <= 1'b0;
          bad_q  <= '0;
          good_q <= '0;
        end else begin
          bad_q <= bad_q + 1'b1;
        end
      end else begin
        bad_q <= '0;
      end
    end
  end

  assign sync_o = sync_q;

  // R8
  rise_needs_comma_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_q) |-> $past(hit_any_i));
  // R9
  fall_needs_bad_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sync_q) && $past(active_i)) |-> $past(!valid));
  // R10
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> !sync_q);
endmodule

// File: rtl/rx_word_aligner.sv
module rx_word_aligner #(
  parameter int W        = 10,
  parameter int GOOD_N   = 3,
  parameter int BAD_N    = 4,
  parameter int ONES_MIN = 4,
  parameter int ONES_MAX = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] din_i,
  input  logic         align_en_i,
  input  logic         slip_i,
  output logic [W-1:0] data_o,
  output logic         det_o,
  output logic         sync_o
);
  import rxwa_pkg::*;

  localparam int OW = $clog2(W);

  align_mode_e   mode;
  logic [W-1:0]  sel;
  logic [W-1:0]  hit;
  logic [OW-1:0] off;
  logic [OW-1:0] hit_pos;
  logic          hit_any;
  logic          sync_int;

  assign mode = align_mode_e'(mode_i);

  rxwa_window #(.W(W), .OW(OW)) u_window (
    .clk   (clk),
    .rst   (rst),
    .din_i (din_i),
    .off_i (off),
    .sel_o (sel),
    .hit_o (hit)
  );

  rxwa_offset_ctl #(.W(W), .OW(OW)) u_offset (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode),
    .en_i      (align_en_i),
    .slip_i    (slip_i),
    .hit_i     (hit),
    .sync_i    (sync_int),
    .hit_any_o (hit_any),
    .hit_pos_o (hit_pos),
    .off_o     (off)
  );

  rxwa_sync #(
    .W(W), .OW(OW), .GOOD_N(GOOD_N), .BAD_N(BAD_N),
    .ONES_MIN(ONES_MIN), .ONES_MAX(ONES_MAX)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .active_i  (mode == AM_AUTO),
    .hit_any_i (hit_any),
    .hit_pos_i (hit_pos),
    .sel_i     (sel),
    .sync_o    (sync_int)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      det_o  <= 1'b0;
    end else begin
      data_o <= sel;
      det_o  <= (sel == W'(COMMA_RDN)) || (sel == W'(COMMA_RDP));
    end
  end

  assign sync_o = sync_int;

  // R7
  det_is_comma_chk: assert property (@(posedge clk) disable iff (rst)
    det_o |-> (data_o == W'(COMMA_RDN) || data_o == W'(COMMA_RDP)));
endmodule

// File: tb/rx_word_aligner_bench.sv
module rx_word_aligner_bench;
  localparam logic [9:0] CN   = 10'b0011111010;
  localparam logic [9:0] CP   = 10'b1100000101;
  localparam logic [9:0] BADW = 10'b1101101101;

  typedef struct packed {
    logic [1:0] mode;
    logic [3:0] shift;
    logic [4:0] slips;
    logic       en;
    logic       aligned;
  } scen_t;

  localparam int NSC = 8;
  localparam scen_t TBL [NSC] = '{
    '{2'd0, 4'd0, 5'd0,  1'b1, 1'b1},
    '{2'd0, 4'd6, 5'd0,  1'b1, 1'b1},
    '{2'd1, 4'd4, 5'd0,  1'b1, 1'b1},
    '{2'd2, 4'd3, 5'd7,  1'b0, 1'b1},
    '{2'd2, 4'd3, 5'd17, 1'b0, 1'b1},
    '{2'd2, 4'd3, 5'd0,  1'b0, 1'b0},
    '{2'd3, 4'd8, 5'd0,  1'b0, 1'b1},
    '{2'd0, 4'd5, 5'd0,  1'b0, 1'b0}
  };
  localparam string LBL [NSC] = '{"R1 R2", "R2", "R3", "R4", "R4 wrap", "R5", "R8", "R2 hold"};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [9:0] din = '0;
  logic       en = 1'b0;
  logic       slip = 1'b0;
  logic [9:0] data_o;
  logic       det_o, sync_o;

  int checks = 0;
  int errors = 0;
  int shift = 0;
  int symmode = 0;
  int n = 0;
  int nslip = 0;
  bit en_on = 1'b0;

  always #10 clk = ~clk;

  rx_word_aligner u_rx_word_aligner (
    .clk(clk), .rst(rst), .mode_i(mode), .din_i(din), .align_en_i(en),
    .slip_i(slip), .data_o(data_o), .det_o(det_o), .sync_o(sync_o)
  );

  function automatic logic [9:0] sym(int i);
    if (i % 8 == 0) return ((i / 8) % 2 == 1) ? CP : CN;
    if (symmode == 1 || (symmode == 2 && i % 8 == 3)) return BADW;
    case (i % 4)
      0:       return 10'b0101010101;
      1:       return 10'b0110011001;
      2:       return 10'b1001100110;
      default: return 10'b0011001101;
    endcase
  endfunction

  function automatic logic [9:0] word_at(int idx, int s);
    logic [9:0] w;
    logic [9:0] t;
    for (int b = 0; b < 10; b++) begin
      int p;
      p = 10 * idx + s + b;
      t = sym(p / 10);
      w[b] = t[p % 10];
    end
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    din = word_at(n, shift);
    n++;
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b0; slip = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n = 0;
    din = word_at(0, shift);
    n = 1;
  endtask

  task automatic run(int cycles, int from, bit aligned, string lbl);
    for (int c = 0; c < cycles; c++) begin
      slip = (mode == 2'd2) && (n >= 2) && (n < 2 + 2 * nslip) && (n % 2 == 0);
      en = en_on && (n >= 3);
      cyc();
      if (c >= from) begin
        if (aligned) begin
          int idx;
          logic [9:0] e;
          idx = (shift == 0) ? n - 4 : n - 3;
          e = sym(idx);
          chk(lbl, data_o, e);
          chk({lbl, " R7"}, det_o, (e == CN || e == CP));
        end else begin
          chk(lbl, det_o, 0);
        end
        if (mode != 2'd3) chk("R10", sync_o, 0);
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    // table-driven scenarios
    for (int t = 0; t < NSC; t++) begin
      shift = int'(TBL[t].shift); symmode = 0; mode = TBL[t].mode;
      nslip = int'(TBL[t].slips); en_on = TBL[t].en;
      do_reset();
      run(60, 40, TBL[t].aligned, LBL[t]);
    end

    // R11: reset state while reset is held
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R11", data_o, 0); chk("R11", det_o, 0); chk("R11", sync_o, 0);
    // R11: offset 0 after reset (unaligned stream at phase 0 stays correct)
    mode = 2'd0; shift = 0; en_on = 1'b0; nslip = 0;
    do_reset();
    run(20, 10, 1'b1, "R11");

    // R6: comma found at every phase, both disparities
    for (int s = 0; s < 10; s++) begin
      mode = 2'd0; shift = s; en_on = 1'b1;
      do_reset();
      run(30, 18, 1'b1, "R6");
    end

    // R2: enable low holds offset through a phase move, then relocks
    mode = 2'd0; shift = 6; en_on = 1'b1;
    do_reset();
    run(30, 18, 1'b1, "R2");
    en_on = 1'b0; shift = 2;
    run(30, 10, 1'b0, "R2");
    en_on = 1'b1;
    run(30, 15, 1'b1, "R2");

    // R3: enable held high gives no second realign; new edge does
    mode = 2'd1; shift = 4; en_on = 1'b1;
    do_reset();
    run(30, 18, 1'b1, "R3");
    shift = 5;
    run(30, 10, 1'b0, "R3");
    en_on = 1'b0;
    run(3, 3, 1'b0, "R3");
    en_on = 1'b1;
    run(30, 15, 1'b1, "R3");

    // R8: sync rises exactly after the third comma
    mode = 2'd3; shift = 2; en_on = 1'b0; symmode = 0;
    do_reset();
    while (n < 26) cyc();
    chk("R8", sync_o, 0);
    cyc();
    chk("R8", sync_o, 1);

    // R9: long runs of bad groups drop sync
    run(10, 0, 1'b1, "R8");
    symmode = 1;
    seen = 1'b0;
    for (int c = 0; c < 20; c++) begin
      cyc();
      if (!sync_o) seen = 1'b1;
    end
    chk("R9", seen, 1);

    // R9: isolated bad groups keep sync
    symmode = 2; shift = 7;
    do_reset();
    while (n < 30) cyc();
    chk("R9", sync_o, 1);
    seen = 1'b0;
    for (int c = 0; c < 40; c++) begin
      cyc();
      if (!sync_o) seen = 1'b1;
    end
    chk("R9", seen, 0);

    // R8: commas at moving offsets never synchronize
    symmode = 0; shift = 1;
    do_reset();
    seen = 1'b0;
    for (int c = 0; c < 80; c++) begin
      shift = 1 + ((n + 4) / 8) % 3;
      cyc();
      if (sync_o) seen = 1'b1;
    end
    chk("R8", seen, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule